// File: doc/BRIEF.md
# RAM-Tag Set-Associative Data Cache

This block is a conventional set-associative primary data cache. Each way is a sub-bank with its own tag RAM, valid bits and data RAM. In the default mode a lookup reads the tag and the addressed word from every way of the selected set at once. One comparator per way finds the hitting way, and only that way's word reaches the response bus. A selectable two-phase mode reads data only from the way that matched, one cycle after the tag check. Stores always use two cycles: a tag check, then a write into the hitting way.

The processor side is a 32-bit word-addressed request port with a stall output, plus a response strobe and response data. The memory side is a line-refill port. It names the missing line and accepts eight 32-bit beats, one per cycle. The victim is an invalid way when one exists, and otherwise comes from a per-set round-robin pointer. A store miss first allocates the line and then performs the store. The cache writes no dirty lines back to memory.

Top module: `rtag_cache`

## Requirements
- R1: While reset is asserted and after it is released, every line is invalid, and `stall`, `rspValid` and `fillReq` are low while no request is pending.
- R2: A request is accepted on a rising edge where `reqValid` is high and `stall` is low. In normal mode (`twoPhase`=0) a read that hits raises `rspValid` with the addressed word in the first cycle after acceptance, with `stall` low, so the next request can be accepted at the end of that same cycle.
- R3: In two-phase mode (`twoPhase`=1, held until the response) a read that hits gives no response in the first cycle after acceptance. It raises `rspValid` with the word, read from the matching way only, in the second cycle.
- R4: A store that hits holds `stall` high with no response in the first cycle after acceptance. It raises `rspValid` in the second cycle, and later reads of that word return the stored value.
- R5: On a miss, `fillReq` rises in the second cycle after acceptance, with `stall` high, and `fillLine` = `reqAddr[29:3]`. The line arrives as 8 beats in word order 0 to 7, one per cycle in which `fillValid` is high. After the eighth beat there is one lookup cycle, and the request then completes as a hit: a normal read responds 10 cycles after acceptance, and a two-phase read or a store responds 11 cycles after acceptance.
- R6: The victim is the lowest-numbered invalid way of the set. When all ways are valid, the victim is the way named by that set's round-robin pointer. The pointer is 0 after reset and advances by one, modulo the way count, each time it chooses a victim.
- R7: `reqAddr` is a word address. Bits [2:0] select the word in the line, bits [7:3] select the set, and bits [29:8] form the tag.
- R8: With one way (direct-mapped), `rspData` carries the stored word of the addressed set and offset in the lookup cycle whether or not the tag matches. `rspValid` is raised only with a match.
- R9: `fillReq` stays high and `fillLine` stays stable until the eighth beat, and `rspValid` stays low during the whole refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| twoPhase | input | 1 | 1 selects tag-then-data reads |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 30 | Word address |
| reqWdata | input | 32 | Store data |
| stall | output | 1 | High when a request cannot be accepted at this edge |
| rspValid | output | 1 | Load data or store completion this cycle |
| rspData | output | 32 | Load data |
| fillReq | output | 1 | Refill in progress |
| fillLine | output | 27 | Line number being refilled |
| fillValid | input | 1 | Refill beat present |
| fillData | input | 32 | Refill beat data |

## Verification
In normal mode, the response to one read hit and the acceptance of the next request fall in the same cycle. The bench provokes this by holding `reqValid` high across two hitting reads to different ways of one set. It checks that `stall` stays low and that the two words appear on consecutive cycles, each one matching a reference model that tracks tags, valid bits and round-robin pointers. A seeded stream of loads and stores, mixed across both modes over a few crowded sets, then judges every hit or miss, every latency, every refill line number and every data word against that model.

// File: rtl/rtag_pkg.sv
package rtag_pkg;

  typedef enum logic [1:0] {
    ST_LOOK,
    ST_PH2,
    ST_STW,
    ST_FILL
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldReq;     // capture the accepted request
    logic latchWay;  // remember hitting way or victim
    logic ph2Sel;    // second phase: data from latched way only
    logic storeWr;   // write store data into latched way
    logic fillWr;    // write one refill beat
    logic fillDone;  // last beat: install tag and valid
  } ctlStrobe_t;

endpackage

// File: rtl/rtag_dp.sv
module rtag_dp
  import rtag_pkg::*;
#(
  parameter int WAYS       = 2,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  ctlStrobe_t                                    st,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]            reqAddr,
  input  logic [DATA_W-1:0]                             reqWdata,
  input  logic [DATA_W-1:0]                             fillData,
  output logic                                          hit,
  output logic                                          fillLast,
  output logic [DATA_W-1:0]                             rdData,
  output logic [ADDR_W-$clog2(DATA_W/8)-$clog2(LINE_WORDS)-1:0] fillLine
);

  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int WA_W   = ADDR_W - BYTE_W;
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = WA_W - IDX_W - OFF_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int BANK_D = SETS * LINE_WORDS;

  logic [WA_W-1:0]   rqWord;
  logic [DATA_W-1:0] rqWdata;
  logic [TAG_W-1:0]  rqTag;
  logic [IDX_W-1:0]  rqIdx;
  logic [OFF_W-1:0]  rqOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rqWord  <= '0;
      rqWdata <= '0;
    end else if (st.ldReq) begin
      rqWord  <= reqAddr;
      rqWdata <= reqWdata;
    end
  end

  assign rqTag = rqWord[WA_W-1 -: TAG_W];
  assign rqIdx = rqWord[OFF_W +: IDX_W];
  assign rqOff = rqWord[OFF_W-1:0];

  logic [WAYS-1:0]   validBits [SETS];
  logic [WAY_W-1:0]  rrCnt     [SETS];
  logic [OFF_W-1:0]  fillCnt;
  logic [WAY_W-1:0]  wayQ;
  logic              rrUseQ;
  logic [WAYS-1:0]   hitVec;
  logic [DATA_W-1:0] wayWord [WAYS];

  // one sub-bank per way: tag RAM plus data RAM
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]       tagRam [SETS];
    logic [DATA_W-1:0]      bank   [BANK_D];
    logic                   bankWe;
    logic [IDX_W+OFF_W-1:0] bankIdx;
    logic [DATA_W-1:0]      bankDin;

    always_comb begin
      bankWe  = (st.storeWr || st.fillWr) && (wayQ == WAY_W'(w));
      bankIdx = st.fillWr ? {rqIdx, fillCnt} : {rqIdx, rqOff};
      bankDin = st.fillWr ? fillData : rqWdata;
    end

    always_ff @(posedge clk) begin
      if (bankWe) bank[bankIdx] <= bankDin;
      if (st.fillDone && (wayQ == WAY_W'(w))) tagRam[rqIdx] <= rqTag;
    end

    assign wayWord[w] = bank[{rqIdx, rqOff}];
    assign hitVec[w]  = validBits[rqIdx][w] && (tagRam[rqIdx] == rqTag);
  end

  logic [WAY_W-1:0] hitIdx;
  always_comb begin
    hitIdx = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitIdx = WAY_W'(w);
  end
  assign hit = |hitVec;

  if (WAYS == 1) begin : g_direct
    // forwarded without waiting for the compare
    assign rdData = wayWord[0];
  end else begin : g_assoc
    always_comb begin
      rdData = '0;
      if (st.ph2Sel) rdData = wayWord[wayQ];
      else
        for (int w = 0; w < WAYS; w++)
          if (hitVec[w]) rdData |= wayWord[w];
    end
  end

  // victim: lowest invalid way, else round-robin pointer
  logic [WAY_W-1:0] victim;
  logic             victimRr;
  always_comb begin
    victim   = rrCnt[rqIdx];
    victimRr = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validBits[rqIdx][w]) begin
        victim   = WAY_W'(w);
        victimRr = 1'b0;
      end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wayQ   <= '0;
      rrUseQ <= 1'b0;
    end else if (st.latchWay) begin
      wayQ   <= hit ? hitIdx : victim;
      rrUseQ <= !hit && victimRr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validBits[s] <= '0;
        rrCnt[s]     <= '0;
      end
      fillCnt <= '0;
    end else begin
      if (st.fillWr) fillCnt <= fillCnt + 1'b1;
      if (st.fillDone) begin
        validBits[rqIdx][wayQ] <= 1'b1;
        if (rrUseQ)
          rrCnt[rqIdx] <= (rrCnt[rqIdx] == WAY_W'(WAYS - 1)) ? '0 : rrCnt[rqIdx] + 1'b1;
      end
    end
  end

  assign fillLast = (fillCnt == OFF_W'(LINE_WORDS - 1));
  assign fillLine = {rqTag, rqIdx};

endmodule

// File: rtl/rtag_ctl.sv
module rtag_ctl
  import rtag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       twoPhase,
  input  logic       hit,
  input  logic       fillLast,
  input  logic       fillValid,
  output logic       stall,
  output logic       rspValid,
  output logic       fillReq,
  output ctlStrobe_t st
);

  ctlState_t state, nextState;
  logic      rqValid, rqWrite;

  always_comb begin
    nextState = state;
    stall     = 1'b1;
    rspValid  = 1'b0;
    fillReq   = 1'b0;
    st        = '0;
    case (state)
      ST_LOOK: begin
        if (!rqValid) begin
          stall = 1'b0;
        end else begin
          st.latchWay = 1'b1;
          if (!hit)          nextState = ST_FILL;
          else if (rqWrite)  nextState = ST_STW;
          else if (twoPhase) nextState = ST_PH2;
          else begin
            rspValid = 1'b1;
            stall    = 1'b0;
          end
        end
      end
      ST_PH2: begin
        st.ph2Sel = 1'b1;
        rspValid  = 1'b1;
        stall     = 1'b0;
        nextState = ST_LOOK;
      end
      ST_STW: begin
        st.storeWr = 1'b1;
        rspValid   = 1'b1;
        stall      = 1'b0;
        nextState  = ST_LOOK;
      end
      ST_FILL: begin
        fillReq = 1'b1;
        if (fillValid) begin
          st.fillWr = 1'b1;
          if (fillLast) begin
            st.fillDone = 1'b1;
            nextState   = ST_LOOK;
          end
        end
      end
      default: nextState = ST_LOOK;
    endcase
    st.ldReq = !stall && reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LOOK;
      rqValid <= 1'b0;
      rqWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (!stall) begin
        rqValid <= reqValid;
        rqWrite <= reqWrite;
      end
    end
  end

endmodule

// File: rtl/rtag_cache.sv
module rtag_cache
  import rtag_pkg::*;
#(
  parameter int WAYS       = 2,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                twoPhase,
  input  logic                                reqValid,
  input  logic                                reqWrite,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]  reqAddr,
  input  logic [DATA_W-1:0]                   reqWdata,
  output logic                                stall,
  output logic                                rspValid,
  output logic [DATA_W-1:0]                   rspData,
  output logic                                fillReq,
  output logic [ADDR_W-$clog2(DATA_W/8)-$clog2(LINE_WORDS)-1:0] fillLine,
  input  logic                                fillValid,
  input  logic [DATA_W-1:0]                   fillData
);

  localparam int LINE_NUM_W = ADDR_W - $clog2(DATA_W/8) - $clog2(LINE_WORDS);

  ctlStrobe_t st;
  logic       hit, fillLast;

  rtag_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .twoPhase (twoPhase),
    .hit      (hit),
    .fillLast (fillLast),
    .fillValid(fillValid),
    .stall    (stall),
    .rspValid (rspValid),
    .fillReq  (fillReq),
    .st       (st)
  );

  rtag_dp #(
    .WAYS      (WAYS),
    .SETS      (SETS),
    .LINE_WORDS(LINE_WORDS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .fillData(fillData),
    .hit     (hit),
    .fillLast(fillLast),
    .rdData  (rspData),
    .fillLine(fillLine)
  );

endmodule

// File: rtl/rtag_cache_chk.sv
module rtag_cache_chk #(
  parameter int LINE_W = 27
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              twoPhase,
  input logic              stall,
  input logic              rspValid,
  input logic              fillReq,
  input logic [LINE_W-1:0] fillLine
);

  // R2: a response cycle never blocks the next request
  p_rsp_nostall_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !stall);

  // R3: two-phase read never answers in its first cycle
  p_twophase_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && twoPhase && !stall) |=> !rspValid);

  // R4: store spends its first cycle on the tag check
  p_store_check_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !stall) |=> (stall && !rspValid));

  // R5: refill blocks new requests
  p_fill_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> stall);

  // R9: no response while a refill runs
  p_no_rsp_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !rspValid);

  // R9: refill line number held for the whole refill
  p_fill_line_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && $past(fillReq)) |-> $stable(fillLine));

endmodule

bind rtag_cache rtag_cache_chk #(.LINE_W(LINE_NUM_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .twoPhase(twoPhase),
  .stall   (stall),
  .rspValid(rspValid),
  .fillReq (fillReq),
  .fillLine(fillLine)
);

// File: tb/sim_rtag_cache.sv
module sim_rtag_cache;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        twoPhase = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [29:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        stall, rspValid, fillReq;
  logic [31:0] rspData;
  logic [26:0] fillLine;
  logic        fillValid = 1'b0;
  logic [31:0] fillData = '0;

  // direct-mapped instance
  logic        r1Valid = 1'b0;
  logic [29:0] r1Addr = '0;
  logic        zero1 = 1'b0;
  logic [31:0] zeroW = '0;
  logic        stall1, rsp1Valid, f1Req;
  logic [31:0] rsp1Data;
  logic [26:0] f1Line;
  logic        f1Valid = 1'b0;
  logic [31:0] f1Data = '0;

  int checks = 0;
  int bad = 0;
  int fillBeats = 0;
  int beat0 = 0;
  int beat1 = 0;
  logic [26:0] lastFillLine = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtag_cache u0 (
    .clk(clk), .rstN(rstN), .twoPhase(twoPhase), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .stall(stall), .rspValid(rspValid), .rspData(rspData),
    .fillReq(fillReq), .fillLine(fillLine), .fillValid(fillValid), .fillData(fillData)
  );

  rtag_cache #(.WAYS(1)) u1 (
    .clk(clk), .rstN(rstN), .twoPhase(zero1), .reqValid(r1Valid),
    .reqWrite(zero1), .reqAddr(r1Addr), .reqWdata(zeroW),
    .stall(stall1), .rspValid(rsp1Valid), .rspData(rsp1Data),
    .fillReq(f1Req), .fillLine(f1Line), .fillValid(f1Valid), .fillData(f1Data)
  );

  function automatic logic [31:0] pat(input logic [29:0] wa);
    return {2'b00, wa} * 32'h9E3779B1 + 32'h13579BDF;
  endfunction

  // refill responders: one beat per cycle while requested
  always @(negedge clk) begin
    if (fillReq) begin
      if (beat0 == 0) lastFillLine = fillLine;
      fillValid = 1'b1;
      fillData  = pat({fillLine, 3'(beat0)});
      beat0++;
      fillBeats++;
    end else begin
      fillValid = 1'b0;
      beat0 = 0;
    end
  end

  always @(negedge clk) begin
    if (f1Req) begin
      f1Valid = 1'b1;
      f1Data  = pat({f1Line, 3'(beat1)});
      beat1++;
    end else begin
      f1Valid = 1'b0;
      beat1 = 0;
    end
  end

  // reference model of the 2-way, 32-set, 8-word configuration
  bit          refV [32][2];
  int          refT [32][2];
  int          refRr [32];
  logic [31:0] refD [32][2][8];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  task automatic doAccess(input bit wr, input bit ph, input int tg, input int ix,
                          input int of, input logic [31:0] wd);
    logic [29:0] wa;
    int          way;
    int          startBeats;
    int          lat;
    int          expLat;
    bit          expHit;
    logic [31:0] got;
    string       latReq;
    wa  = {tg[21:0], ix[4:0], of[2:0]};
    way = -1;
    for (int w = 0; w < 2; w++)
      if (refV[ix][w] && refT[ix][w] == tg) way = w;
    expHit = (way >= 0);
    if (!expHit) begin
      for (int w = 1; w >= 0; w--)
        if (!refV[ix][w]) way = w;
      if (way < 0) begin
        way = refRr[ix];
        refRr[ix] = (refRr[ix] + 1) % 2;
      end
      refV[ix][way] = 1'b1;
      refT[ix][way] = tg;
      for (int k = 0; k < 8; k++) refD[ix][way][k] = pat({wa[29:3], 3'(k)});
    end
    startBeats = fillBeats;
    @(negedge clk);
    twoPhase = ph; reqValid = 1'b1; reqWrite = wr; reqAddr = wa; reqWdata = wd;
    while (stall) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    got = rspData;
    // R6: hit or miss follows the replacement choice
    check((fillBeats - startBeats) == (expHit ? 0 : 8), "R6 hit/miss beats",
          32'(fillBeats - startBeats), expHit ? 32'd0 : 32'd8);
    if (!expHit)
      check(lastFillLine == wa[29:3], "R5 fill line", 32'(lastFillLine), 32'(wa[29:3]));
    expLat = (expHit ? 0 : 9) + ((!wr && !ph) ? 1 : 2);
    if (!expHit)      latReq = "R5 miss latency";
    else if (wr)      latReq = "R4 store latency";
    else if (ph)      latReq = "R3 two-phase latency";
    else              latReq = "R2 read latency";
    check(lat == expLat, latReq, 32'(lat), 32'(expLat));
    if (wr) refD[ix][way][of] = wd;
    else    check(got == refD[ix][way][of], "R7 read data", got, refD[ix][way][of]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int lcg;
    int n;
    logic [29:0] aA, aB;
    for (int s = 0; s < 32; s++) begin
      refRr[s] = 0;
      for (int w = 0; w < 2; w++) begin
        refV[s][w] = 1'b0;
        refT[s][w] = 0;
      end
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(!stall, "R1 stall", 32'(stall), 0);
    check(!rspValid, "R1 rspValid", 32'(rspValid), 0);
    check(!fillReq, "R1 fillReq", 32'(fillReq), 0);

    // sweep all sets with three tags: fills both ways, then round-robin evicts
    for (int ix = 0; ix < 32; ix++)
      for (int tg = 0; tg < 3; tg++)
        doAccess(1'b0, tg == 2, tg, ix, ix % 8, '0);

    // R2: back-to-back hits, response and next acceptance share a cycle
    aA = {22'd1, 5'd5, 3'd3};
    aB = {22'd2, 5'd5, 3'd6};
    @(negedge clk);
    twoPhase = 1'b0; reqWrite = 1'b0; reqValid = 1'b1; reqAddr = aA;
    check(!stall, "R2 idle accept", 32'(stall), 0);
    @(negedge clk);
    check(rspValid && rspData == refD[5][1][3], "R2 first of pair", rspData, refD[5][1][3]);
    check(!stall, "R2 no stall on hit", 32'(stall), 0);
    reqAddr = aB;
    @(negedge clk);
    check(rspValid && rspData == refD[5][0][6], "R2 second of pair", rspData, refD[5][0][6]);
    reqValid = 1'b0;

    // mixed loads and stores in both modes over four crowded sets
    lcg = 32'h2468ACE1;
    for (int i = 0; i < 500; i++) begin
      int r;
      lcg = lcg * 1103515245 + 12345;
      r = lcg >>> 1;
      doAccess(((r >> 12) % 5) < 2, (r >> 16) & 1, r % 4, (r >> 4) % 4, (r >> 8) % 8,
               pat(30'(lcg)) ^ 32'h5A5A5A5A);
    end

    // R8: direct-mapped forwarding of the stored word before the compare
    aA = {22'd0, 5'd2, 3'd3};
    aB = {22'd1, 5'd2, 3'd3};
    @(negedge clk);
    r1Valid = 1'b1; r1Addr = aA;
    @(negedge clk);
    r1Valid = 1'b0;
    n = 0;
    while (!rsp1Valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(rsp1Valid && rsp1Data == pat(aA), "R8 direct-mapped fill", rsp1Data, pat(aA));
    @(negedge clk);
    r1Valid = 1'b1; r1Addr = aB;
    @(negedge clk);
    r1Valid = 1'b0;
    check(!rsp1Valid, "R8 no valid on mismatch", 32'(rsp1Valid), 0);
    check(rsp1Data == pat(aA), "R8 forwarded word", rsp1Data, pat(aA));
    n = 0;
    while (!rsp1Valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(rsp1Valid && rsp1Data == pat(aB), "R8 direct-mapped refill", rsp1Data, pat(aB));

    summary();
    $finish;
  end

endmodule